// File: doc/BRIEF.md
# Main Clock Source Switch and Domain Divider

This block builds the synchronous clocks of a small controller from two free-running inputs: the output of a generic clock generator and the output of a low-power frequency-locked loop. One register bit picks the source. The change of source runs through a two-stage handshake. The old source is shut off on its own falling edge first, and only then is the new source let through on its own falling edge. As a result no high or low phase on the main clock is ever shorter than it would be on either source.

The main clock drives a single free-running counter. That counter produces a CPU clock and a peripheral-bus clock, each at the main rate divided by a power of two from 1 to 128. Every peripheral clock and the controller's own bus-interface clock are gated copies of the bus clock. The gating uses latch-based enable cells that are transparent while the clock is low. Software configures the block through a small write/read register port and polls a ready flag after it requests a new source.

Top module: `mclk_ctrl`

## Requirements
- R1: After reset the source select is 0, both divider codes are 0 (ratio 1), every mask bit is 1, the self-clock enable is 1 and the ready flag is 1.
- R2: Register address 0 bit 0 is the source select. 0 routes the generator input and 1 routes the FLL input to `clk_main`. Once ready is set, the `clk_main` period equals the period of the selected input.
- R3: No high or low phase of `clk_main` is shorter than the shorter half-period of the two inputs, and the two source enables are never on together.
- R4: Address 0 bit 1 is the read-only ready flag. Any write to address 0 clears it by the next register clock. It sets again only once the requested source alone drives `clk_main`.
- R5: Address 1 bits [2:0] hold the CPU code c and bits [6:4] hold the bus code b. `clk_cpu` runs at 2^c and `clk_bus` at 2^b main periods. Every `clk_bus` rising edge coincides with a `clk_cpu` rising edge.
- R6: A write to address 1 with b < c is ignored, and the register reads back its previous value.
- R7: Address 2 bit i masks `clk_periph[i]`. With the bit at 0 the output has no edges. With the bit at 1 it pulses at the bus rate.
- R8: Address 3 bit 0 enables `clk_self`. Writing 0 clears it and stops that clock. Any later write of 1 leaves it at 0 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_gen | input | 1 | Generic clock generator output (source 0) |
| clk_fll | input | 1 | Low-power FLL output (source 1) |
| cfg_clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr |
| clk_main | output | 1 | Selected main clock |
| clk_cpu | output | 1 | CPU domain clock |
| clk_bus | output | 1 | Peripheral-bus domain clock |
| clk_periph | output | NP | Per-peripheral gated bus clocks |
| clk_self | output | 1 | Gated clock for the controller's own bus interface |

## Verification
The source handshake and a divider update can land on the same stretch of main-clock cycles. In that case the divider codes are loaded at a counter wrap, while `clk_main` is itself moving from one source to the other. The bench provokes this by writing a new select value and then, on the next register cycle, a random divider pair. It then polls ready. A monitor on `clk_main` phase widths runs throughout. Once things settle, the bench measures the CPU and bus periods against the source and ratios that its own model predicts.

// File: rtl/mclk_pkg.sv
`timescale 1ns/1ps
package mclk_pkg;
  localparam int LOG_W = 3;                    // divider code width
  localparam int CNT_W = (1 << LOG_W) - 1;     // counter bits for ratios up to 2^CNT_W
  localparam int BUS_LSB = 4;                  // bus code field offset in the divider register

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_DIV  = 2'd1,
    A_MASK = 2'd2,
    A_SELF = 2'd3
  } addr_e;

  // low k bits set: a domain ticks when these counter bits are all zero
  function automatic logic [CNT_W-1:0] low_mask(input logic [LOG_W-1:0] k);
    logic [CNT_W:0] m;
    m = ((CNT_W+1)'(1) << k) - (CNT_W+1)'(1);
    return m[CNT_W-1:0];
  endfunction

  // the bus domain may never be faster than the CPU domain
  function automatic logic div_pair_ok(input logic [LOG_W-1:0] cpu, input logic [LOG_W-1:0] bus);
    return bus >= cpu;
  endfunction
endpackage

// File: rtl/mclk_sync.sv
`timescale 1ns/1ps
module mclk_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RV = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RV;
      q    <= RV;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/mclk_clk_gate.sv
`timescale 1ns/1ps
module mclk_clk_gate (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_l;
  always_latch begin
    if (!clk) en_l <= en;
  end
  assign gclk = clk & en_l;
endmodule

// File: rtl/mclk_src_switch.sv
`timescale 1ns/1ps
module mclk_src_switch (
  input  logic clk_gen,
  input  logic clk_fll,
  input  logic rst_n,
  input  logic sel,
  output logic clk_out,
  output logic gen_on,
  output logic fll_on
);
  logic [1:0] gen_s, fll_s;

  // stage 1: request synchronized on the rising edge of each source
  always_ff @(posedge clk_gen or negedge rst_n) begin
    if (!rst_n) gen_s <= 2'b11;
    else        gen_s <= {gen_s[0], ~sel & ~fll_on};
  end
  always_ff @(posedge clk_fll or negedge rst_n) begin
    if (!rst_n) fll_s <= 2'b00;
    else        fll_s <= {fll_s[0], sel & ~gen_on};
  end

  // stage 2: enable changes only while its own clock is low
  always_ff @(negedge clk_gen or negedge rst_n) begin
    if (!rst_n) gen_on <= 1'b1;
    else        gen_on <= gen_s[1];
  end
  always_ff @(negedge clk_fll or negedge rst_n) begin
    if (!rst_n) fll_on <= 1'b0;
    else        fll_on <= fll_s[1];
  end

  assign clk_out = (clk_gen & gen_on) | (clk_fll & fll_on);

  a_r3_exclusive_gen: assert property (@(posedge clk_gen) disable iff (!rst_n)
    !(gen_on && fll_on));
  a_r3_exclusive_fll: assert property (@(posedge clk_fll) disable iff (!rst_n)
    !(gen_on && fll_on));
endmodule

// File: rtl/mclk_divider.sv
`timescale 1ns/1ps
module mclk_divider
  import mclk_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LOG_W-1:0] cpu_code_a,
  input  logic [LOG_W-1:0] bus_code_a,
  input  logic [NP-1:0]    mask_a,
  input  logic             self_en_a,
  output logic             clk_cpu,
  output logic             clk_bus,
  output logic [NP-1:0]    clk_periph,
  output logic             clk_self,
  output logic             cpu_tick,
  output logic             bus_tick
);
  localparam int VW = 2*LOG_W + NP + 1;
  localparam logic [VW-1:0] CFG_RV = {1'b1, {NP{1'b1}}, {(2*LOG_W){1'b0}}};

  logic [VW-1:0]    cfg_s, cfg_q;
  logic [CNT_W-1:0] cnt;
  logic [LOG_W-1:0] cur_cpu, cur_bus;
  logic [NP-1:0]    mask_s;
  logic             self_s;
  logic             wrap;

  mclk_sync #(.W(VW), .RV(CFG_RV)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({self_en_a, mask_a, bus_code_a, cpu_code_a}),
    .q(cfg_s)
  );
  assign {self_s, mask_s} = cfg_s[VW-1:2*LOG_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RV;
      cnt     <= '0;
      cur_cpu <= '0;
      cur_bus <= '0;
    end else begin
      cfg_q <= cfg_s;
      cnt   <= cnt + 1'b1;
      // codes move only at a wrap and only from a word seen twice in a row
      if (wrap && cfg_s == cfg_q) begin
        cur_cpu <= cfg_s[LOG_W-1:0];
        cur_bus <= cfg_s[2*LOG_W-1:LOG_W];
      end
    end
  end

  assign wrap     = (cnt == '1);
  assign cpu_tick = (cnt & low_mask(cur_cpu)) == '0;
  assign bus_tick = (cnt & low_mask(cur_bus)) == '0;

  mclk_clk_gate u_g_cpu  (.clk(clk), .en(cpu_tick),           .gclk(clk_cpu));
  mclk_clk_gate u_g_bus  (.clk(clk), .en(bus_tick),           .gclk(clk_bus));
  mclk_clk_gate u_g_self (.clk(clk), .en(bus_tick && self_s), .gclk(clk_self));

  for (genvar i = 0; i < NP; i++) begin : g_periph
    mclk_clk_gate u_g (.clk(clk), .en(bus_tick && mask_s[i]), .gclk(clk_periph[i]));
  end

  a_r5_bus_on_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    bus_tick |-> cpu_tick);
  a_r5_codes_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |-> ($stable(cur_cpu) && $stable(cur_bus)));
endmodule

// File: rtl/mclk_regs.sv
`timescale 1ns/1ps
module mclk_regs
  import mclk_pkg::*;
#(
  parameter int NP = 8,
  parameter int DW = 8
) (
  input  logic             cfg_clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  input  logic             gen_on_a,
  input  logic             fll_on_a,
  output logic             sel,
  output logic [LOG_W-1:0] cpu_code,
  output logic [LOG_W-1:0] bus_code,
  output logic [NP-1:0]    mask,
  output logic             self_en
);
  logic [1:0]       on_s;
  logic             ready, done, wr_ctrl, wr_div;
  logic [LOG_W-1:0] w_cpu, w_bus;
  addr_e            a;

  mclk_sync #(.W(2), .RV(2'b10)) u_sync (
    .clk(cfg_clk), .rst_n(rst_n), .d({gen_on_a, fll_on_a}), .q(on_s)
  );

  assign a       = addr_e'(reg_addr);
  assign wr_ctrl = reg_we && a == A_CTRL;
  assign wr_div  = reg_we && a == A_DIV;
  assign w_cpu   = reg_wdata[LOG_W-1:0];
  assign w_bus   = reg_wdata[BUS_LSB +: LOG_W];
  // the requested source alone is on
  assign done    = sel ? (on_s[0] && !on_s[1]) : (on_s[1] && !on_s[0]);

  always_ff @(posedge cfg_clk or negedge rst_n) begin
    if (!rst_n) begin
      sel      <= 1'b0;
      ready    <= 1'b1;
      cpu_code <= '0;
      bus_code <= '0;
      mask     <= '1;
      self_en  <= 1'b1;
    end else begin
      if (wr_ctrl) begin
        sel   <= reg_wdata[0];
        ready <= 1'b0;
      end else if (done) begin
        ready <= 1'b1;
      end
      if (wr_div && div_pair_ok(w_cpu, w_bus)) begin
        cpu_code <= w_cpu;
        bus_code <= w_bus;
      end
      if (reg_we && a == A_MASK) mask <= reg_wdata[NP-1:0];
      if (reg_we && a == A_SELF) self_en <= self_en & reg_wdata[0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (a)
      A_CTRL: reg_rdata[1:0] = {ready, sel};
      A_DIV: begin
        reg_rdata[LOG_W-1:0]         = cpu_code;
        reg_rdata[BUS_LSB +: LOG_W]  = bus_code;
      end
      A_MASK: reg_rdata[NP-1:0] = mask;
      default: reg_rdata[0] = self_en;
    endcase
  end

  a_r4_write_clears: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    wr_ctrl |=> !ready);
  a_r4_rise_needs_done: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(ready) |-> $past(done));
  a_r6_pair_legal: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    bus_code >= cpu_code);
  a_r8_sticky_off: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !self_en |=> !self_en);
endmodule

// File: rtl/mclk_ctrl.sv
`timescale 1ns/1ps
module mclk_ctrl
  import mclk_pkg::*;
#(
  parameter int NP = 8,
  parameter int DW = 8
) (
  input  logic          clk_gen,
  input  logic          clk_fll,
  input  logic          cfg_clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          clk_main,
  output logic          clk_cpu,
  output logic          clk_bus,
  output logic [NP-1:0] clk_periph,
  output logic          clk_self
);
  logic             sel, gen_on, fll_on, self_en, cpu_tick, bus_tick;
  logic [LOG_W-1:0] cpu_code, bus_code;
  logic [NP-1:0]    mask;

  mclk_regs #(.NP(NP), .DW(DW)) u_regs (
    .cfg_clk(cfg_clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gen_on_a(gen_on), .fll_on_a(fll_on),
    .sel(sel), .cpu_code(cpu_code), .bus_code(bus_code), .mask(mask), .self_en(self_en)
  );

  mclk_src_switch u_sw (
    .clk_gen(clk_gen), .clk_fll(clk_fll), .rst_n(rst_n), .sel(sel),
    .clk_out(clk_main), .gen_on(gen_on), .fll_on(fll_on)
  );

  mclk_divider #(.NP(NP)) u_div (
    .clk(clk_main), .rst_n(rst_n), .cpu_code_a(cpu_code), .bus_code_a(bus_code),
    .mask_a(mask), .self_en_a(self_en), .clk_cpu(clk_cpu), .clk_bus(clk_bus),
    .clk_periph(clk_periph), .clk_self(clk_self), .cpu_tick(cpu_tick), .bus_tick(bus_tick)
  );

  a_r5_bus_implies_cpu_pulse: assert property (@(posedge clk_main) disable iff (!rst_n)
    bus_tick |-> cpu_tick);
endmodule

// File: tb/sim_mclk_ctrl.sv
`timescale 1ns/1ps
module sim_mclk_ctrl;
  localparam int NP = 8;
  localparam int DW = 8;
  localparam real T_GEN = 14.0;
  localparam real T_FLL = 34.0;

  logic          cfg_clk = 0, clk_gen = 0, clk_fll = 0, rst_n = 0;
  logic          reg_we = 0;
  logic [1:0]    reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0;
  logic [DW-1:0] reg_rdata;
  logic          clk_main, clk_cpu, clk_bus, clk_self;
  logic [NP-1:0] clk_periph;

  int n_cmp = 0, n_bad = 0;
  int glitches = 0;
  bit mon_on = 0;
  realtime last_t = 0;
  int pe_cnt [NP];
  int self_cnt = 0;

  always #10  cfg_clk = ~cfg_clk;
  always #7   clk_gen = ~clk_gen;
  always #17  clk_fll = ~clk_fll;

  mclk_ctrl #(.NP(NP), .DW(DW)) u0 (
    .clk_gen(clk_gen), .clk_fll(clk_fll), .cfg_clk(cfg_clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .clk_main(clk_main), .clk_cpu(clk_cpu), .clk_bus(clk_bus),
    .clk_periph(clk_periph), .clk_self(clk_self)
  );

  // R3 phase-width monitor on the main clock
  always @(clk_main) begin
    if (mon_on && ($realtime - last_t) < 6.5) glitches++;
    last_t = $realtime;
  end

  for (genvar i = 0; i < NP; i++) begin : g_cnt
    initial pe_cnt[i] = 0;
    always @(posedge clk_periph[i]) pe_cnt[i]++;
  end
  always @(posedge clk_self) self_cnt++;

  function automatic int exp_tenths(input real src, input int k);
    return $rtoi(src * 10.0) * (1 << k);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge cfg_clk);
    reg_we = 1; reg_addr = 2'(addr); reg_wdata = DW'(data);
    @(negedge cfg_clk);
    reg_we = 0;
  endtask

  task automatic rd(input int addr, output int data);
    @(negedge cfg_clk);
    reg_addr = 2'(addr);
    #1 data = int'(reg_rdata);
  endtask

  task automatic wait_ready(input string req);
    int v = 0;
    for (int n = 0; n < 500; n++) begin
      rd(0, v);
      if (v[1]) break;
    end
    check({req, " ready"}, v[1], 1);
  endtask

  task automatic settle();
    repeat (300) @(posedge clk_main);
  endtask

  // 0: main, 1: cpu, 2: bus ; result in tenths of ns
  task automatic period_of(input int which, output int p);
    realtime t0;
    case (which)
      0: begin @(posedge clk_main); t0 = $realtime; @(posedge clk_main); end
      1: begin @(posedge clk_cpu);  t0 = $realtime; @(posedge clk_cpu);  end
      default: begin @(posedge clk_bus); t0 = $realtime; @(posedge clk_bus); end
    endcase
    p = $rtoi(($realtime - t0) * 10.0 + 0.5);
  endtask

  task automatic do_reset();
    rst_n = 0;
    #95;
    @(negedge cfg_clk);
    rst_n = 1;
  endtask

  int v, p, m_cpu, m_bus, m_sel, m_mask;
  real src;
  int snap [NP];
  int s0;

  initial begin
    void'($urandom(32'd5150));
    do_reset();
    #200 mon_on = 1;

    // R1 reset state
    rd(0, v); check("R1 ctrl", v, 2);
    rd(1, v); check("R1 div", v, 0);
    rd(2, v); check("R1 mask", v, 255);
    rd(3, v); check("R1 self", v, 1);
    settle();
    period_of(0, p); check("R1 R2 main from gen", p, exp_tenths(T_GEN, 0));
    period_of(1, p); check("R1 cpu ratio 1", p, exp_tenths(T_GEN, 0));
    m_sel = 0; m_cpu = 0; m_bus = 0;

    // R2 + R4 switch to FLL
    wr(0, 1);
    rd(0, v); check("R4 cleared after write", v[1], 0);
    wait_ready("R4");
    rd(0, v); check("R2 sel bit", v[0], 1);
    m_sel = 1;
    period_of(0, p); check("R2 main from fll", p, exp_tenths(T_FLL, 0));

    // R5 directed
    wr(1, 8'h31); rd(1, v); check("R5 div readback", v, 8'h31);
    m_cpu = 1; m_bus = 3;
    settle();
    period_of(1, p); check("R5 cpu period", p, exp_tenths(T_FLL, 1));
    period_of(2, p); check("R5 bus period", p, exp_tenths(T_FLL, 3));

    // R6 illegal pair ignored
    wr(1, 8'h24); rd(1, v); check("R6 illegal ignored", v, 8'h31);
    settle();
    period_of(1, p); check("R6 cpu unchanged", p, exp_tenths(T_FLL, 1));

    // R5 maximum ratio
    wr(1, 8'h77); rd(1, v); check("R5 max readback", v, 8'h77);
    m_cpu = 7; m_bus = 7;
    settle();
    period_of(2, p); check("R5 bus at 128", p, exp_tenths(T_FLL, 7));

    // back to gen, R2
    wr(1, 8'h10); m_cpu = 0; m_bus = 1;
    wr(0, 0); wait_ready("R4 back"); m_sel = 0;
    settle();
    period_of(0, p); check("R2 main back on gen", p, exp_tenths(T_GEN, 0));
    period_of(2, p); check("R5 bus ratio 2", p, exp_tenths(T_GEN, 1));

    // R7 mask
    m_mask = int'($urandom_range(1, 254));
    wr(2, m_mask); rd(2, v); check("R7 mask readback", v, m_mask);
    settle();
    for (int i = 0; i < NP; i++) snap[i] = pe_cnt[i];
    #3000;
    for (int i = 0; i < NP; i++)
      check($sformatf("R7 periph %0d running", i), int'(pe_cnt[i] > snap[i]), m_mask >> i & 1);

    // R8 sticky self enable
    wr(3, 0); rd(3, v); check("R8 cleared", v, 0);
    wr(3, 1); rd(3, v); check("R8 stays cleared", v, 0);
    settle(); s0 = self_cnt; #3000;
    check("R8 self clock stopped", self_cnt - s0, 0);

    // random phase with switch/divider collisions
    for (int it = 0; it < 12; it++) begin
      int c, b, ns;
      c = int'($urandom_range(0, 7));
      b = int'($urandom_range(0, 7));
      ns = int'($urandom_range(0, 1));
      wr(0, ns);
      wr(1, (b << 4) | c);
      if (b >= c) begin m_cpu = c; m_bus = b; end
      m_sel = ns;
      wait_ready("R4 random");
      rd(1, v); check("R5 R6 random div", v, (m_bus << 4) | m_cpu);
      src = (m_sel != 0) ? T_FLL : T_GEN;
      settle();
      period_of(0, p); check("R2 random main", p, exp_tenths(src, 0));
      period_of(1, p); check("R5 random cpu", p, exp_tenths(src, m_cpu));
      period_of(2, p); check("R5 random bus", p, exp_tenths(src, m_bus));
    end

    check("R3 phase widths", glitches, 0);

    // R8 reset restores the enable
    mon_on = 0;
    do_reset();
    rd(3, v); check("R8 restored by reset", v, 1);
    settle(); s0 = self_cnt; #3000;
    check("R8 self clock back", int'(self_cnt > s0), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #3_500_000;
    n_bad++;
    n_cmp++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule